// File: doc/BRIEF.md
# Pixel Serial-to-Parallel Readout Port

This block sits between a successive-approximation converter and the board's backplane. Each converted pixel arrives as a serial stream of 16 ones-complement bits, one bit per conversion clock. The conversion clock is derived by division from the system clock. Inside the block that clock appears as a one-cycle bit strobe in the system clock domain. The block gathers the bits in a shift register and counts them. A rising edge on the latch line moves the gathered word into a holding register. This double buffering lets the converter start on the next pixel while the host is still reading the previous one.

A backplane read is decoded against a 5-bit board identity set by jumpers. The four address bits supply the low four bits of the comparison. The memory-space select supplies the fifth bit: space 0 is the default and space 1 reaches sixteen further boards. On a matching read the block enables its output and drives a 24-bit word with the fields listed in R9. The bus is tri-state on the board, so it is modelled here as an enable plus a data vector.

Top module: `pxp_readout_port`

## Requirements
- R1: After reset the holding register is zero, the bit counter is zero, `word_full` and `short_word` are low, and a matching read returns zero pixel data.
- R2: On each cycle with `bit_stb` high, `ser_in` is shifted in most significant bit first. After 16 strobes and a latch edge, the held word equals the 16 bits in arrival order, with the first bit at bit 15.
- R3: `word_full` is high exactly when 16 or more bits have arrived since the last latch edge, and the counter saturates at 16. Further bits keep shifting, so only the last 16 bits are latched.
- R4: Only a rising edge of `lat_in` copies into the holding register. Holding `lat_in` high while more bits arrive does not copy again.
- R5: Bits shifted after a latch edge do not change the held word until the next latch edge.
- R6: A latch edge with fewer than 16 bits latches the partial word right-aligned, with zeros above it, and sets `short_word`. Every latch edge clears the shift register and the counter.
- R7: `short_word` is sticky: a later full-word latch does not clear it, and only reset does.
- R8: `rd_oe` is high only when `rd_req` is high and the concatenation {`rd_space`, `rd_addr`} equals `board_id`.
- R9: When `rd_oe` is high, `rd_data` carries the held pixel on bits 15:0, `board_id` on bits 20:16 and zeros on bits 23:21. When `rd_oe` is low, `rd_data` is all zeros.
- R10: If a bit strobe and a latch edge fall in the same cycle, the word gathered before that cycle is latched. The new bit becomes the first bit of the next word, and the counter then reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe per conversion clock rising edge |
| ser_in | input | 1 | Serial converter data bit |
| lat_in | input | 1 | Latch control line; its rising edge is acted on |
| board_id | input | 5 | Jumper board identity |
| rd_req | input | 1 | Backplane read cycle active |
| rd_space | input | 1 | Memory-space select (0 default, 1 alternate) |
| rd_addr | input | 4 | Read address bits |
| rd_oe | output | 1 | Output enable of the backplane drivers |
| rd_data | output | 24 | Read word |
| word_full | output | 1 | 16 bits gathered since the last latch |
| short_word | output | 1 | Sticky flag: a latch occurred on a short word |

## Verification
The hardest case to reach is a bit strobe and a latch edge landing in the same system clock cycle. That case decides whether the boundary bit goes to the old word or the new one. The bench places the two on purpose in one cycle after a full word. It then completes the next word and checks both held values. Partial-word latches are swept over every length from 1 to 15, and each expected value is computed as the right-shifted pattern.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
  localparam int PIX_W_DEF = 16;
  localparam int ID_W_DEF  = 5;
  localparam int BUS_W_DEF = 24;

  // Saturating increment used by the bit counter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/pxp_shift.sv
module pxp_shift #(
  parameter int PIX_W = 16,
  localparam int CNT_W = $clog2(PIX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             ser_in,
  input  logic             lat_rise,
  output logic [PIX_W-1:0] sh_word,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             full
);
  import pxp_pkg::*;

  logic [CNT_W-1:0] cnt_next;

  always_comb cnt_next = CNT_W'(sat_inc(int'(bit_cnt), PIX_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_word <= '0;
      bit_cnt <= '0;
    end else if (lat_rise) begin
      sh_word <= {{(PIX_W-1){1'b0}}, ser_in & bit_stb};
      bit_cnt <= bit_stb ? CNT_W'(1) : '0;
    end else if (bit_stb) begin
      sh_word <= {sh_word[PIX_W-2:0], ser_in};
      bit_cnt <= cnt_next;
    end
  end

  assign full = (bit_cnt == CNT_W'(PIX_W));
endmodule

// File: rtl/pxp_hold.sv
module pxp_hold #(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_in,
  input  logic [PIX_W-1:0] sh_word,
  input  logic             full,
  output logic             lat_rise,
  output logic [PIX_W-1:0] held,
  output logic             short_word
);
  logic lat_q;

  assign lat_rise = lat_in & ~lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q      <= 1'b0;
      held       <= '0;
      short_word <= 1'b0;
    end else begin
      lat_q <= lat_in;
      if (lat_rise) begin
        held <= sh_word;
        if (!full) short_word <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pxp_decode.sv
module pxp_decode #(
  parameter int PIX_W = 16,
  parameter int ID_W  = 5,
  parameter int BUS_W = 24,
  localparam int ADR_W = ID_W - 1,
  localparam int PAD_W = BUS_W - PIX_W - ID_W
) (
  input  logic             rd_req,
  input  logic             rd_space,
  input  logic [ADR_W-1:0] rd_addr,
  input  logic [ID_W-1:0]  board_id,
  input  logic [PIX_W-1:0] held,
  output logic             hit,
  output logic             rd_oe,
  output logic [BUS_W-1:0] rd_data
);
  function automatic logic [BUS_W-1:0] pack_word(input logic [ID_W-1:0] id,
                                                 input logic [PIX_W-1:0] pix);
    return {{PAD_W{1'b0}}, id, pix};
  endfunction

  assign hit     = ({rd_space, rd_addr} == board_id);
  assign rd_oe   = rd_req & hit;
  assign rd_data = rd_oe ? pack_word(board_id, held) : '0;
endmodule

// File: rtl/pxp_readout_port.sv
module pxp_readout_port #(
  parameter int PIX_W = pxp_pkg::PIX_W_DEF,
  parameter int ID_W  = pxp_pkg::ID_W_DEF,
  parameter int BUS_W = pxp_pkg::BUS_W_DEF,
  localparam int ADR_W = ID_W - 1,
  localparam int CNT_W = $clog2(PIX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             ser_in,
  input  logic             lat_in,
  input  logic [ID_W-1:0]  board_id,
  input  logic             rd_req,
  input  logic             rd_space,
  input  logic [ADR_W-1:0] rd_addr,
  output logic             rd_oe,
  output logic [BUS_W-1:0] rd_data,
  output logic             word_full,
  output logic             short_word
);
  logic             lat_rise_w;
  logic [PIX_W-1:0] sh_word_w;
  logic [CNT_W-1:0] bit_cnt_w;
  logic [PIX_W-1:0] held_w;
  logic             hit_w;

  pxp_shift #(.PIX_W(PIX_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .ser_in(ser_in),
    .lat_rise(lat_rise_w), .sh_word(sh_word_w), .bit_cnt(bit_cnt_w),
    .full(word_full)
  );

  pxp_hold #(.PIX_W(PIX_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .lat_in(lat_in), .sh_word(sh_word_w),
    .full(word_full), .lat_rise(lat_rise_w), .held(held_w),
    .short_word(short_word)
  );

  pxp_decode #(.PIX_W(PIX_W), .ID_W(ID_W), .BUS_W(BUS_W)) u_dec (
    .rd_req(rd_req), .rd_space(rd_space), .rd_addr(rd_addr),
    .board_id(board_id), .held(held_w), .hit(hit_w), .rd_oe(rd_oe),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/pxp_readout_chk.sv
module pxp_readout_chk #(
  parameter int PIX_W = 16,
  parameter int ID_W  = 5,
  parameter int BUS_W = 24,
  localparam int CNT_W = $clog2(PIX_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_stb,
  input logic             lat_rise_w,
  input logic [CNT_W-1:0] bit_cnt_w,
  input logic [PIX_W-1:0] held_w,
  input logic             hit_w,
  input logic             rd_req,
  input logic             rd_oe,
  input logic [BUS_W-1:0] rd_data,
  input logic             short_word
);
  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_w <= CNT_W'(PIX_W));

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise_w |=> $stable(held_w));

  p_short_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise_w && bit_cnt_w != CNT_W'(PIX_W)) |=> short_word);

  p_latch_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise_w && !bit_stb) |=> bit_cnt_w == '0);

  p_short_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    short_word |=> short_word);

  p_oe_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (rd_req && hit_w));

  p_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> rd_data == '0);

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:PIX_W+ID_W] == '0);

  p_bit_after_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise_w && bit_stb) |=> bit_cnt_w == CNT_W'(1));
endmodule

bind pxp_readout_port pxp_readout_chk #(.PIX_W(PIX_W), .ID_W(ID_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .lat_rise_w(lat_rise_w),
  .bit_cnt_w(bit_cnt_w), .held_w(held_w), .hit_w(hit_w), .rd_req(rd_req),
  .rd_oe(rd_oe), .rd_data(rd_data), .short_word(short_word)
);

// File: tb/pxp_readout_port_test.sv
module pxp_readout_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, ser_in = 1'b0, lat_in = 1'b0;
  logic [4:0] board_id = 5'd0;
  logic rd_req = 1'b0, rd_space = 1'b0;
  logic [3:0] rd_addr = 4'd0;
  logic rd_oe, word_full, short_word;
  logic [23:0] rd_data;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pxp_readout_port uut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .ser_in(ser_in),
    .lat_in(lat_in), .board_id(board_id), .rd_req(rd_req),
    .rd_space(rd_space), .rd_addr(rd_addr), .rd_oe(rd_oe),
    .rd_data(rd_data), .word_full(word_full), .short_word(short_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_stb = 1'b0; lat_in = 1'b0; rd_req = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic shift_bit(input logic b);
    bit_stb = 1'b1; ser_in = b;
    tick();
    bit_stb = 1'b0;
  endtask

  task automatic shift_bits(input logic [15:0] pat, input int n);
    for (int i = 15; i > 15 - n; i--) shift_bit(pat[i]);
  endtask

  task automatic pulse_latch();
    lat_in = 1'b1; tick();
    lat_in = 1'b0; tick();
  endtask

  task automatic read_held(output logic [15:0] pix, output logic oe, output logic [7:0] hi);
    rd_req = 1'b1; rd_space = board_id[4]; rd_addr = board_id[3:0];
    #1;
    pix = rd_data[15:0]; oe = rd_oe; hi = rd_data[23:16];
    tick();
    rd_req = 1'b0;
  endtask

  task automatic expect_held(input string req, input logic [15:0] exp);
    logic [15:0] pix; logic oe; logic [7:0] hi;
    read_held(pix, oe, hi);
    check(req, {15'd0, oe, pix}, {15'd0, 1'b1, exp});
    check("R9 id field", {24'd0, hi}, {24'd0, 3'b000, board_id});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [5];
    pats[0] = 16'hA5C3; pats[1] = 16'h0001; pats[2] = 16'h8000;
    pats[3] = 16'hFFFF; pats[4] = 16'h1234;

    board_id = 5'd21;
    do_reset();
    // R1 reset state
    check("R1 word_full", {31'd0, word_full}, 0);
    check("R1 short_word", {31'd0, short_word}, 0);
    check("R1 oe idle", {31'd0, rd_oe}, 0);
    expect_held("R1 held zero", 16'h0000);

    // R8/R9 address sweep, several identities
    for (int k = 0; k < 4; k++) begin
      board_id = (k == 0) ? 5'd0 : (k == 1) ? 5'd15 : (k == 2) ? 5'd21 : 5'd31;
      for (int a = 0; a < 32; a++) begin
        for (int q = 0; q < 2; q++) begin
          rd_req = q[0]; rd_space = a[4]; rd_addr = a[3:0];
          #1;
          check("R8 oe decode", {31'd0, rd_oe},
                {31'd0, (q == 1) && (a[4:0] == board_id)});
          if (!rd_oe) check("R9 idle data", {8'd0, rd_data}, 0);
          else check("R9 layout", {8'd0, rd_data}, {8'd0, 3'b000, board_id, 16'h0000});
          tick();
        end
      end
      rd_req = 1'b0;
    end

    board_id = 5'd19;
    // R2/R3/R5 full words
    for (int p = 0; p < 5; p++) begin
      shift_bits(pats[p], 15);
      check("R3 not full at 15", {31'd0, word_full}, 0);
      shift_bit(pats[p][0]);
      check("R3 full at 16", {31'd0, word_full}, 1);
      if (p > 0) expect_held("R5 held unchanged by shifting", pats[p-1]);
      pulse_latch();
      check("R6 counter cleared", {31'd0, word_full}, 0);
      expect_held("R2 msb-first word", pats[p]);
    end
    check("R7 no short after full words", {31'd0, short_word}, 0);

    // R3 overrun: 20 bits, last 16 kept
    shift_bits(16'hF000, 4);
    shift_bits(16'h3C5A, 16);
    check("R3 saturated full", {31'd0, word_full}, 1);
    pulse_latch();
    expect_held("R3 last 16 bits", 16'h3C5A);

    // R4 level-held latch
    shift_bits(16'h6E21, 16);
    lat_in = 1'b1; tick();
    shift_bits(16'h9999, 16);
    expect_held("R4 no recopy while high", 16'h6E21);
    lat_in = 1'b0; tick();
    lat_in = 1'b1; tick(); lat_in = 1'b0; tick();
    expect_held("R4 new edge copies", 16'h9999);

    // R6/R7 short words, all lengths 1..15
    for (int n = 1; n < 16; n++) begin
      do_reset();
      shift_bits(16'hB7E5, n);
      pulse_latch();
      expect_held("R6 partial right aligned", 16'hB7E5 >> (16 - n));
      check("R6 short flag", {31'd0, short_word}, 1);
    end
    shift_bits(16'h0F0F, 16);
    pulse_latch();
    expect_held("R2 full after short", 16'h0F0F);
    check("R7 sticky after full latch", {31'd0, short_word}, 1);
    do_reset();
    check("R7 cleared by reset", {31'd0, short_word}, 0);

    // R10 bit and latch edge in same cycle
    shift_bits(16'h5AA5, 16);
    bit_stb = 1'b1; ser_in = 1'b1; lat_in = 1'b1;
    tick();
    bit_stb = 1'b0; lat_in = 1'b0;
    tick();
    expect_held("R10 old word latched", 16'h5AA5);
    shift_bits(16'h0000, 15);
    check("R10 new word full", {31'd0, word_full}, 1);
    pulse_latch();
    expect_held("R10 boundary bit leads next word", 16'h8000);
    check("R10 no short", {31'd0, short_word}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule